// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs the processor side of one coprocessor transaction. A transaction can be one of five kinds: a load of memory words into the coprocessor, a store of coprocessor words to memory, a move from a core register to the coprocessor, a move from the coprocessor to a core register, or a data operation inside the coprocessor.

A one-cycle `start` pulse launches a transaction and carries the kind, the coprocessor number and a base address. A per-coprocessor enable mask decides whether the access is allowed at all. The sequencer then presents phase codes to the coprocessor and samples its 2-bit answer once per cycle. For loads and stores it issues word memory requests. The transaction always ends with a single `done` pulse that carries its outcome:

- a normal finish,
- undefined instruction,
- coprocessor abort,
- vector-region abort, or
- an interrupt that broke a busy-wait.

While the coprocessor answers busy, the sequencer inserts one idle cycle before it asks again. In that idle cycle a pending reset, fast interrupt or normal interrupt request abandons the instruction. A load or store burst continues word by word for as long as the coprocessor keeps answering "increment".

Top module: `cpx_seq`

## Requirements
- R1: If the enable bit for the addressed coprocessor is clear, or the kind code is not one of 0 (load), 1 (store), 2 (move to coprocessor), 3 (move from coprocessor), 4 (data operation), then `done` and `undef` are high one cycle after `start` and no phase other than 0 (none) is presented.
- R2: For an enabled transaction, phase 1 (first) is presented in the cycle after `start`.
- R3: An answer of 1 (busy) to phase 1 or 2 (busy) is followed by exactly one cycle of phase 0. Phase 2 is presented in the cycle after that.
- R4: If an interrupt is pending in that idle cycle, phase 3 (interrupt) is presented for one cycle. `done` then follows with `int_code` non-zero, and no memory request is made.
- R5: `int_code` is 1 when `rst_req` is high. Otherwise it is 2 when `fiq_req` is high and `fiq_mask` is low. Otherwise it is 3 when `irq_req` is high and `irq_mask` is low. A masked request does not stop the busy-wait.
- R6: An answer of 2 (cannot) raises `cp_abort` for loads and stores, and `undef` for the other kinds. At most one of `undef`, `cp_abort`, `vec_abort` and a non-zero `int_code` is high with `done`.
- R7: After an answer of 0 (go) or 3 (increment) to phase 1 or 2, a load or store presents phase 4 (data) with a memory request at the base address. Each data-phase answer of 3 adds one more word at the previous address plus 4. `mem_we` is high for a store only.
- R8: A store whose base address is below `VEC_LIMIT` ends with `vec_abort` after the go-ahead and makes no memory request.
- R9: A move from the coprocessor that gets the go-ahead captures `cp_rdata` at that answer. It then spends one phase-5 (coprocessor) cycle and one idle cycle before `done` and `res_valid`. If the coprocessor answers "cannot", `res_data` is `FLAG_VAL`.
- R10: Each accepted `start` produces exactly one `done` pulse. A `start` while a transaction is running is ignored. After reset the phase is 0 and `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| kind | input | 3 | Transaction kind code |
| cp_num | input | CPW | Addressed coprocessor |
| cp_enable | input | NCP | Per-coprocessor access enable |
| base_addr | input | AW | First word address |
| cp_rsp | input | 2 | Coprocessor answer: 0 go, 1 busy, 2 cannot, 3 increment |
| cp_rdata | input | DW | Coprocessor read data for a move out |
| rst_req | input | 1 | Pending reset request |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt mask |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt mask |
| cp_phase | output | 3 | Phase code presented to the coprocessor |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| done | output | 1 | End-of-transaction pulse |
| undef | output | 1 | Undefined-instruction outcome |
| cp_abort | output | 1 | Coprocessor abort outcome |
| vec_abort | output | 1 | Vector-region abort outcome |
| int_code | output | 2 | Interrupt that ended the transaction |
| res_valid | output | 1 | Register result valid |
| res_data | output | DW | Register result |

## Verification
Every answer the coprocessor model gives is sampled at the next rising edge, so each result is due a fixed number of cycles after `start`:

- `done` comes 1 cycle after `start` for a refused access.
- Otherwise the first answer falls in cycle 1 and each busy round adds 2 cycles.
- An interrupt ends the transaction 2 cycles after its idle cycle.
- A burst ends 1 cycle after its last data phase.
- A move out ends 3 cycles after the go-ahead.

The bench computes this latency from the stimulus and counts falling edges from the start edge. It compares the count at which `done` is seen, together with every outcome flag and every data-phase address sampled at those falling edges.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
   typedef enum logic [2:0] {
      PH_NONE  = 3'd0,
      PH_FIRST = 3'd1,
      PH_BUSY  = 3'd2,
      PH_INTR  = 3'd3,
      PH_DATA  = 3'd4,
      PH_CCYC  = 3'd5
   } cpx_phase_e;

   localparam logic [2:0] K_LOAD  = 3'd0;
   localparam logic [2:0] K_STORE = 3'd1;
   localparam logic [2:0] K_MTO   = 3'd2;
   localparam logic [2:0] K_MFROM = 3'd3;
   localparam logic [2:0] K_OP    = 3'd4;

   localparam logic [1:0] RSP_GO   = 2'd0;
   localparam logic [1:0] RSP_BUSY = 2'd1;
   localparam logic [1:0] RSP_CANT = 2'd2;
   localparam logic [1:0] RSP_INC  = 2'd3;

   localparam logic [1:0] INT_NONE  = 2'd0;
   localparam logic [1:0] INT_RESET = 2'd1;
   localparam logic [1:0] INT_FAST  = 2'd2;
   localparam logic [1:0] INT_NORM  = 2'd3;
endpackage

// File: rtl/cpx_int_arb.sv
module cpx_int_arb
   import cpx_pkg::*;
(
   input  logic       rst_req,
   input  logic       fiq_req,
   input  logic       fiq_mask,
   input  logic       irq_req,
   input  logic       irq_mask,
   output logic [1:0] code
);
   always_comb begin
      if (rst_req)                   code = INT_RESET;
      else if (fiq_req && !fiq_mask) code = INT_FAST;
      else if (irq_req && !irq_mask) code = INT_NORM;
      else                           code = INT_NONE;
   end
endmodule

// File: rtl/cpx_vec_chk.sv
module cpx_vec_chk #(
   parameter int unsigned     AW        = 32,
   parameter logic [AW-1:0]   VEC_LIMIT = 32
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   generate
      if (VEC_LIMIT == '0) begin : g_no_region
         assign hit = 1'b0;
      end else begin : g_region
         assign hit = (addr < VEC_LIMIT);
      end
   endgenerate
endmodule

// File: rtl/cpx_seq.sv
module cpx_seq
   import cpx_pkg::*;
#(
   parameter int unsigned   NCP       = 16,
   parameter int unsigned   AW        = 32,
   parameter int unsigned   DW        = 32,
   parameter logic [AW-1:0] VEC_LIMIT = 32,
   parameter logic [DW-1:0] FLAG_VAL  = {4'hF, {(DW-4){1'b0}}},
   localparam int unsigned  CPW       = (NCP > 1) ? $clog2(NCP) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     kind,
   input  logic [CPW-1:0] cp_num,
   input  logic [NCP-1:0] cp_enable,
   input  logic [AW-1:0]  base_addr,
   input  logic [1:0]     cp_rsp,
   input  logic [DW-1:0]  cp_rdata,
   input  logic           rst_req,
   input  logic           fiq_req,
   input  logic           fiq_mask,
   input  logic           irq_req,
   input  logic           irq_mask,
   output logic [2:0]     cp_phase,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic           done,
   output logic           undef,
   output logic           cp_abort,
   output logic           vec_abort,
   output logic [1:0]     int_code,
   output logic           res_valid,
   output logic [DW-1:0]  res_data
);
   localparam logic [AW-1:0] WORD_STEP = AW'(4);

   generate
      if (NCP < 2 || (1 << CPW) != NCP) begin : g_bad_ncp
         $error("NCP must be a power of two of at least 2");
      end
      if (AW < 8 || DW < 4) begin : g_bad_width
         $error("AW must be at least 8 and DW at least 4");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR, S_DATA, S_CCYC, S_ICYC
   } st_e;

   st_e            st;
   logic [2:0]     kind_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  res_q;
   logic [1:0]     int_hold;
   logic           done_q, undef_q, cpab_q, vab_q, rv_q;
   logic [1:0]     int_q;
   logic [1:0]     pend_code;
   logic           vec_hit;
   logic           kind_ok;
   logic           is_mem;

   cpx_int_arb u_arb (
      .rst_req (rst_req),
      .fiq_req (fiq_req),
      .fiq_mask(fiq_mask),
      .irq_req (irq_req),
      .irq_mask(irq_mask),
      .code    (pend_code)
   );

   cpx_vec_chk #(.AW(AW), .VEC_LIMIT(VEC_LIMIT)) u_vec (
      .addr(addr_q),
      .hit (vec_hit)
   );

   assign kind_ok = (kind <= K_OP);
   assign is_mem  = (kind_q == K_LOAD) || (kind_q == K_STORE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         kind_q   <= '0;
         addr_q   <= '0;
         res_q    <= '0;
         int_hold <= INT_NONE;
         done_q   <= 1'b0;
         undef_q  <= 1'b0;
         cpab_q   <= 1'b0;
         vab_q    <= 1'b0;
         rv_q     <= 1'b0;
         int_q    <= INT_NONE;
      end else begin
         done_q  <= 1'b0;
         undef_q <= 1'b0;
         cpab_q  <= 1'b0;
         vab_q   <= 1'b0;
         rv_q    <= 1'b0;
         int_q   <= INT_NONE;
         case (st)
            S_IDLE: begin
               if (start) begin
                  kind_q <= kind;
                  addr_q <= base_addr;
                  if (!cp_enable[cp_num] || !kind_ok) begin
                     done_q  <= 1'b1;
                     undef_q <= 1'b1;
                  end else begin
                     st <= S_FIRST;
                  end
               end
            end
            S_FIRST, S_BUSY: begin
               if (cp_rsp == RSP_BUSY) begin
                  st <= S_WAIT;
               end else if (cp_rsp == RSP_CANT) begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                  if (is_mem) cpab_q  <= 1'b1;
                  else        undef_q <= 1'b1;
                  if (kind_q == K_MFROM) begin
                     rv_q  <= 1'b1;
                     res_q <= FLAG_VAL;
                  end
               end else if (is_mem) begin
                  if (kind_q == K_STORE && vec_hit) begin
                     st     <= S_IDLE;
                     done_q <= 1'b1;
                     vab_q  <= 1'b1;
                  end else begin
                     st <= S_DATA;
                  end
               end else if (kind_q == K_MFROM) begin
                  res_q <= cp_rdata;
                  st    <= S_CCYC;
               end else begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
               end
            end
            S_WAIT: begin
               if (pend_code != INT_NONE) begin
                  int_hold <= pend_code;
                  st       <= S_INTR;
               end else begin
                  st <= S_BUSY;
               end
            end
            S_INTR: begin
               st     <= S_IDLE;
               done_q <= 1'b1;
               int_q  <= int_hold;
            end
            S_DATA: begin
               if (cp_rsp == RSP_INC) begin
                  addr_q <= addr_q + WORD_STEP;
               end else begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
               end
            end
            S_CCYC: st <= S_ICYC;
            S_ICYC: begin
               st     <= S_IDLE;
               done_q <= 1'b1;
               rv_q   <= 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   cpx_phase_e ph;
   always_comb begin
      case (st)
         S_FIRST: ph = PH_FIRST;
         S_BUSY:  ph = PH_BUSY;
         S_INTR:  ph = PH_INTR;
         S_DATA:  ph = PH_DATA;
         S_CCYC:  ph = PH_CCYC;
         default: ph = PH_NONE;
      endcase
   end

   assign cp_phase  = ph;
   assign mem_req   = (st == S_DATA);
   assign mem_we    = (kind_q == K_STORE);
   assign mem_addr  = addr_q;
   assign done      = done_q;
   assign undef     = undef_q;
   assign cp_abort  = cpab_q;
   assign vec_abort = vab_q;
   assign int_code  = int_q;
   assign res_valid = rv_q;
   assign res_data  = res_q;

   AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_FIRST) |-> $past(start)); // R2
   AST_IDLE_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_BUSY) |-> ($past(cp_phase) == PH_NONE)); // R3
   AST_INTR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_phase == PH_INTR) |=> (done && int_code != INT_NONE && !mem_req)); // R4
   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot0({undef, cp_abort, vec_abort, int_code != INT_NONE})); // R6
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + WORD_STEP)); // R7
   AST_VEC_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      vec_abort |-> !$past(mem_req)); // R8
endmodule

// File: tb/cpx_seq_tb_top.sv
module cpx_seq_tb_top;
   localparam int NCP = 16;
   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam logic [31:0] VLIM = 32'h20;
   localparam logic [31:0] FLAGV = 32'hF000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  kind = '0;
   logic [3:0]  cp_num = '0;
   logic [15:0] cp_enable = '0;
   logic [31:0] base_addr = '0;
   logic [1:0]  cp_rsp = '0;
   logic [31:0] cp_rdata = '0;
   logic        rst_req = 1'b0, fiq_req = 1'b0, fiq_mask = 1'b0;
   logic        irq_req = 1'b0, irq_mask = 1'b0;
   logic [2:0]  cp_phase;
   logic        mem_req, mem_we, done, undef, cp_abort, vec_abort, res_valid;
   logic [31:0] mem_addr, res_data;
   logic [1:0]  int_code;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cpx_seq #(.NCP(NCP), .AW(AW), .DW(DW), .VEC_LIMIT(VLIM), .FLAG_VAL(FLAGV)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .cp_num(cp_num),
      .cp_enable(cp_enable), .base_addr(base_addr), .cp_rsp(cp_rsp),
      .cp_rdata(cp_rdata), .rst_req(rst_req), .fiq_req(fiq_req),
      .fiq_mask(fiq_mask), .irq_req(irq_req), .irq_mask(irq_mask),
      .cp_phase(cp_phase), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .done(done), .undef(undef), .cp_abort(cp_abort),
      .vec_abort(vec_abort), .int_code(int_code), .res_valid(res_valid),
      .res_data(res_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_int(input bit r, input bit f, input bit fm,
                                           input bit i, input bit im);
      if (r) return 2'd1;
      if (f && !fm) return 2'd2;
      if (i && !im) return 2'd3;
      return 2'd0;
   endfunction

   // lines = {rst_req, fiq_req, irq_req}, driven only in idle cycle number intr_at
   task automatic run_txn(input logic [2:0] k, input logic [3:0] cp, input logic [15:0] mask,
                          input logic [31:0] addr, input int nbusy, input logic [1:0] fin,
                          input int intr_at, input logic [2:0] lines, input bit fm, input bit im,
                          input int ninc, input logic [31:0] rdat, input bit extra);
      bit en, mem, taken;
      logic [1:0] icode;
      int lat, p, ex_beats;
      bit e_undef, e_cpab, e_vab, e_rv;
      logic [31:0] e_res;
      int busy_left, beats, waits, seen_lat, fb_cnt;
      bit last_busy, got;
      logic [31:0] a_undef, a_cpab, a_vab, a_int, a_rv, a_res;

      en = mask[cp] && (k <= 3'd4);
      mem = (k == 3'd0) || (k == 3'd1);
      icode = 2'd0; taken = 0;
      if (en && intr_at >= 0 && intr_at < nbusy) begin
         icode = exp_int(lines[2], lines[1], fm, lines[0], im);
         taken = (icode != 2'd0);
      end
      e_undef = 0; e_cpab = 0; e_vab = 0; e_rv = 0; e_res = 32'h0; ex_beats = 0;
      p = 1 + 2 * nbusy;
      if (!en) begin
         lat = 1; e_undef = 1;
      end else if (taken) begin
         lat = 2 * intr_at + 4;
      end else if (fin == 2'd2) begin
         lat = p + 1;
         if (mem) e_cpab = 1; else e_undef = 1;
         if (k == 3'd3) begin e_rv = 1; e_res = FLAGV; end
      end else if (mem) begin
         if (k == 3'd1 && addr < VLIM) begin
            lat = p + 1; e_vab = 1;
         end else begin
            lat = p + 2 + ninc; ex_beats = ninc + 1;
         end
      end else if (k == 3'd3) begin
         lat = p + 3; e_rv = 1; e_res = rdat;
      end else begin
         lat = p + 1;
      end

      @(negedge clk);
      start = 1; kind = k; cp_num = cp; cp_enable = mask; base_addr = addr;
      cp_rdata = rdat; fiq_mask = fm; irq_mask = im; cp_rsp = 2'd0;
      busy_left = nbusy; beats = 0; waits = 0; last_busy = 0; got = 0;
      seen_lat = 0; fb_cnt = 0;
      a_undef = 0; a_cpab = 0; a_vab = 0; a_int = 0; a_rv = 0; a_res = 0;
      for (int cyc = 1; cyc <= 400; cyc++) begin
         @(negedge clk);
         start = (extra && cyc == 2);
         rst_req = 0; fiq_req = 0; irq_req = 0;
         if (done) begin
            got = 1; seen_lat = cyc;
            a_undef = 32'(undef); a_cpab = 32'(cp_abort); a_vab = 32'(vec_abort);
            a_int = 32'(int_code); a_rv = 32'(res_valid); a_res = res_data;
            break;
         end
         case (cp_phase)
            3'd1, 3'd2: begin
               fb_cnt++;
               if (busy_left > 0) begin
                  cp_rsp = 2'd1; busy_left--; last_busy = 1;
               end else begin
                  cp_rsp = fin;
               end
            end
            3'd0: begin
               if (last_busy) begin
                  if (waits == intr_at) begin
                     rst_req = lines[2]; fiq_req = lines[1]; irq_req = lines[0];
                  end
                  waits++; last_busy = 0;
               end
            end
            3'd4: begin
               chk("R7 data addr", mem_addr, addr + 32'(4 * beats));
               chk("R7 write flag", 32'(mem_we), 32'(k == 3'd1));
               cp_rsp = (beats < ninc) ? 2'd3 : 2'd0;
               beats++;
            end
            default: ;
         endcase
      end
      start = 0; rst_req = 0; fiq_req = 0; irq_req = 0; cp_rsp = 2'd0;
      chk("R10 done seen", 32'(got), 32'd1);
      chk("R2 R3 done latency", 32'(seen_lat), 32'(lat));
      chk("R1 R6 undef", a_undef, 32'(e_undef));
      chk("R6 cp_abort", a_cpab, 32'(e_cpab));
      chk("R8 vec_abort", a_vab, 32'(e_vab));
      chk("R4 R5 int_code", a_int, 32'(icode));
      chk("R7 R4 beats", 32'(beats), 32'(ex_beats));
      chk("R9 res_valid", a_rv, 32'(e_rv));
      if (e_rv) chk("R9 res_data", a_res, e_res);
      if (!en) chk("R1 no phase", 32'(fb_cnt), 32'd0);
      if (extra) begin
         int more = 0;
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done) more++;
         end
         chk("R10 ignored start", 32'(more), 32'd0);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R10 reset phase", 32'(cp_phase), 32'd0);
      chk("R10 reset done", 32'(done), 32'd0);
      chk("R10 reset mem_req", 32'(mem_req), 32'd0);

      // R1: disabled coprocessor and illegal kind
      run_txn(3'd4, 4'd5, 16'hFFDF, 32'h100, 0, 2'd0, -1, 3'b0, 0, 0, 0, 32'h0, 0);
      run_txn(3'd6, 4'd2, 16'hFFFF, 32'h100, 0, 2'd0, -1, 3'b0, 0, 0, 0, 32'h0, 0);
      // R6: cannot on load and on data op
      run_txn(3'd0, 4'd1, 16'hFFFF, 32'h200, 1, 2'd2, -1, 3'b0, 0, 0, 0, 32'h0, 0);
      run_txn(3'd4, 4'd1, 16'hFFFF, 32'h200, 0, 2'd2, -1, 3'b0, 0, 0, 0, 32'h0, 0);
      // R9: rejected move out gives flag value; accepted gives data
      run_txn(3'd3, 4'd3, 16'hFFFF, 32'h0, 2, 2'd2, -1, 3'b0, 0, 0, 0, 32'h1234, 0);
      run_txn(3'd3, 4'd3, 16'hFFFF, 32'h0, 1, 2'd0, -1, 3'b0, 0, 0, 0, 32'hCAFE_F00D, 0);
      // R8: store into vector region, load there is fine
      run_txn(3'd1, 4'd0, 16'hFFFF, 32'h1C, 0, 2'd0, -1, 3'b0, 0, 0, 2, 32'h0, 0);
      run_txn(3'd0, 4'd0, 16'hFFFF, 32'h1C, 0, 2'd0, -1, 3'b0, 0, 0, 2, 32'h0, 0);
      // R7: long store burst
      run_txn(3'd1, 4'd7, 16'hFFFF, 32'h400, 1, 2'd3, -1, 3'b0, 0, 0, 5, 32'h0, 0);
      // R4 R5: priority cases
      run_txn(3'd4, 4'd1, 16'hFFFF, 32'h0, 3, 2'd0, 1, 3'b111, 1, 1, 0, 32'h0, 0);
      run_txn(3'd4, 4'd1, 16'hFFFF, 32'h0, 3, 2'd0, 0, 3'b011, 1, 0, 0, 32'h0, 0);
      run_txn(3'd4, 4'd1, 16'hFFFF, 32'h0, 3, 2'd0, 2, 3'b011, 0, 0, 0, 32'h0, 0);
      run_txn(3'd0, 4'd1, 16'hFFFF, 32'h80, 2, 2'd0, 0, 3'b011, 1, 1, 1, 32'h0, 0);
      // R10: start during a running transaction
      run_txn(3'd2, 4'd9, 16'hFFFF, 32'h0, 3, 2'd0, -1, 3'b0, 0, 0, 0, 32'h0, 1);

      for (int n = 0; n < 250; n++) begin
         logic [2:0] k;
         logic [15:0] m;
         logic [31:0] a;
         int nb, ia;
         logic [1:0] f;
         k = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
         m = ($urandom % 6 == 0) ? 16'($urandom) : 16'hFFFF;
         a = ($urandom % 5 == 0) ? (32'($urandom % 8) << 2) : ({$urandom} & 32'hFFFF_FFFC);
         nb = $urandom % 4;
         f = ($urandom % 5 == 0) ? 2'd2 : (($urandom % 2) ? 2'd0 : 2'd3);
         ia = (nb > 0 && $urandom % 3 == 0) ? int'($urandom % nb) : -1;
         run_txn(k, 4'($urandom), m, a, nb, f, ia, 3'($urandom), 1'($urandom),
                 1'($urandom), $urandom % 4, $urandom, 0);
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule